// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog for the special-function-register (SFR) write bus of a small 8-bit microcontroller. Reset leaves it idle. Software arms it by writing a two-byte key to a write-only key register. Once armed, a counter advances on each machine-cycle strobe. Software must write the same two-byte key again before the count runs out. If the count reaches its limit, the block drives a fixed-length, active-high reset pulse and returns to the idle state. After arming, no software write can turn it off. Only the external reset or its own timeout can do that.

A second register holds a 3-bit scale value S. A prescaler divides the machine-cycle strobe by 2^S before the strobe reaches the main counter, so the timeout becomes 2^S times longer. The machine-cycle strobe comes from outside the block. The counter value cannot be read or written. The pulse is meant to feed the device reset tree.

Top module: `wdt_top`

## Requirements
- R1: While `rstIn` is high, and after it is released, `wdtReset` is low. The block is idle after reset, and the scale value is 0.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to 0xA6, arms the watchdog. With S = 0 and `mcEn` high on every cycle, `wdtReset` is still low 16382 clocks after the arming write and is high 16383 clocks after it.
- R3: A write of any other value to 0xA6 directly after 0x1E cancels the partial key. A write of 0xE1 without a prior 0x1E does not arm the watchdog.
- R4: Writes to addresses other than 0xA6 and 0xA7 do not disturb a partial key sequence.
- R5: While the watchdog is armed, the key sequence clears the prescaler and the counter. The next timeout then comes a full period after the second key byte.
- R6: Once the watchdog is armed, no write turns it off. This includes other values written to 0xA6 and aborted keys.
- R7: The counter advances only on cycles where `mcEn` is high, so a pulse can start only on such a cycle.
- R8: Bits 2:0 written to address 0xA7 set S. The count rate is divided by 2^S, so S = 1 gives a timeout of 32766 machine cycles.
- R9: On a timeout, `wdtReset` stays high for exactly 96 clock cycles.
- R10: A timeout returns the block to idle and sets S back to 0. No second pulse follows until the watchdog is armed again, and re-arming uses the base timeout.
- R11: If the second key byte arrives on the same cycle as the final count, the service takes effect and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstIn | input | 1 | External reset, active high, asynchronous |
| mcEn | input | 1 | Machine-cycle strobe, one clock wide |
| sfrWr | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR write address |
| sfrWdata | input | 8 | SFR write data |
| wdtReset | output | 1 | Reset pulse, active high |

## Verification
The hardest case to reach is a service write that lands on the exact cycle of the final count. At that point the counter is one tick from its limit, and the second key byte must be captured on that same clock edge. The bench arms the watchdog with the strobe held high, so it can count edges from the arming write. It places the first key byte one edge before the limit and the second key byte on the limit edge. It then confirms that no pulse appears and that the next timeout comes one full period later. The prescaled timeout and the effect of gating the strobe are reached in the same way, by counting edges from the arming write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             clear;
    logic             run;
    logic [SEL_W-1:0] sel;
  } wdtCtl_t;
endpackage

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int PRE_W = 7
) (
  input  logic    clk,
  input  logic    rstIn,
  input  logic    mcEn,
  input  wdtCtl_t ctl,
  output logic    ovf
);
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;

  // Low S bits of the prescaler must all be set for a main-counter tick.
  always_comb begin
    preMask = ~({PRE_W{1'b1}} << ctl.sel);
    tick    = ctl.run && mcEn && ((pre & preMask) == preMask);
    ovf     = tick && (cnt == LAST) && !ctl.clear;
  end

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      pre <= '0;
      cnt <= '0;
    end else if (ctl.clear || ovf) begin
      pre <= '0;
      cnt <= '0;
    end else if (ctl.run && mcEn) begin
      pre <= pre + PRE_W'(1);
      if (tick) cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  KEY_ADDR   = 8'hA6,
  parameter logic [7:0]  SEL_ADDR   = 8'hA7,
  parameter logic [7:0]  KEY_FIRST  = 8'h1E,
  parameter logic [7:0]  KEY_SECOND = 8'hE1,
  parameter int          PULSE_LEN  = 96
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              sfrWr,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic              ovf,
  output wdtCtl_t           ctl,
  output logic              pulseOut
);
  localparam int PL_W = $clog2(PULSE_LEN);

  logic             keyWr;
  logic             selWr;
  logic             keyDone;
  logic             keyArmed;
  logic             enabled;
  logic [SEL_W-1:0] selReg;
  logic [PL_W-1:0]  pulseCnt;

  always_comb begin
    keyWr     = sfrWr && (sfrAddr == ADDR_W'(KEY_ADDR));
    selWr     = sfrWr && (sfrAddr == ADDR_W'(SEL_ADDR));
    keyDone   = keyWr && keyArmed && (sfrWdata == DATA_W'(KEY_SECOND));
    ctl.clear = keyDone;
    ctl.run   = enabled;
    ctl.sel   = selReg;
  end

  // Key tracking, enable latch and scale register.
  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      keyArmed <= 1'b0;
      enabled  <= 1'b0;
      selReg   <= '0;
    end else if (ovf) begin
      keyArmed <= 1'b0;
      enabled  <= 1'b0;
      selReg   <= '0;
    end else begin
      if (keyWr) keyArmed <= (sfrWdata == DATA_W'(KEY_FIRST));
      if (keyDone) enabled <= 1'b1;
      if (selWr) selReg <= sfrWdata[SEL_W-1:0];
    end
  end

  // Fixed-length output pulse.
  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      pulseOut <= 1'b0;
      pulseCnt <= '0;
    end else if (ovf) begin
      pulseOut <= 1'b1;
      pulseCnt <= '0;
    end else if (pulseOut) begin
      if (pulseCnt == PL_W'(PULSE_LEN - 1)) pulseOut <= 1'b0;
      else pulseCnt <= pulseCnt + PL_W'(1);
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter int         CNT_W      = 14,
  parameter int         PRE_W      = 7,
  parameter int         PULSE_LEN  = 96,
  parameter logic [7:0] KEY_ADDR   = 8'hA6,
  parameter logic [7:0] SEL_ADDR   = 8'hA7,
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              mcEn,
  input  logic              sfrWr,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic              wdtReset
);
  wdtCtl_t ctl;
  logic    ovf;

  wdt_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .SEL_ADDR(SEL_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .PULSE_LEN(PULSE_LEN)
  ) uCtrl (
    .clk(clk), .rstIn(rstIn), .sfrWr(sfrWr), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .ovf(ovf), .ctl(ctl), .pulseOut(wdtReset)
  );

  wdt_dp #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uDp (
    .clk(clk), .rstIn(rstIn), .mcEn(mcEn), .ctl(ctl), .ovf(ovf)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int PULSE_LEN = 96
) (
  input logic clk,
  input logic rstIn,
  input logic mcEn,
  input logic wdtReset
);
  localparam int HW = $clog2(PULSE_LEN + 1) + 1;

  logic [HW-1:0] hiLen;

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) hiLen <= '0;
    else if (wdtReset) hiLen <= hiLen + HW'(1);
    else hiLen <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rstIn |-> !wdtReset);

  // R7
  rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rstIn)
    $rose(wdtReset) |-> $past(mcEn));

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rstIn)
    $fell(wdtReset) |-> hiLen == HW'(PULSE_LEN));

  // R9
  pulse_cap_chk: assert property (@(posedge clk) disable iff (rstIn)
    wdtReset |-> hiLen < HW'(PULSE_LEN));

  // R10
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rstIn)
    $fell(wdtReset) |=> !wdtReset);
endmodule

bind wdt_top wdt_chk #(.PULSE_LEN(PULSE_LEN)) uChk (
  .clk(clk), .rstIn(rstIn), .mcEn(mcEn), .wdtReset(wdtReset)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16383;
  localparam int PULSE = 96;
  localparam int WATCHDOG_CYCLES = 195000;
  localparam int NVEC = 4;

  // {vld,addr,data} x3, expected armed
  localparam logic [51:0] VECS [NVEC] = '{
    {1'b1, 8'hA6, 8'h1E, 1'b1, 8'hA6, 8'hE1, 1'b0, 8'h00, 8'h00, 1'b1},
    {1'b1, 8'hA6, 8'h1E, 1'b1, 8'hA6, 8'h55, 1'b1, 8'hA6, 8'hE1, 1'b0},
    {1'b1, 8'hA6, 8'hE1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hA6, 8'h1E, 1'b1, 8'hA5, 8'hE1, 1'b1, 8'hA6, 8'hE1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstIn = 1'b1;
  logic       mcEn = 1'b1;
  logic       sfrWr = 1'b0;
  logic [7:0] sfrAddr = '0;
  logic [7:0] sfrWdata = '0;
  logic       wdtReset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdt_top dut (
    .clk(clk), .rstIn(rstIn), .mcEn(mcEn), .sfrWr(sfrWr),
    .sfrAddr(sfrAddr), .sfrWdata(sfrWdata), .wdtReset(wdtReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstIn = 1'b1;
    repeat (3) @(negedge clk);
    rstIn = 1'b0;
    @(negedge clk);
  endtask

  // Called at a negedge; captured on the next posedge; returns one negedge later.
  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    sfrWr = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWr = 1'b0;
  endtask

  task automatic arm();
    sfrWrite(8'hA6, 8'h1E);
    sfrWrite(8'hA6, 8'hE1);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called on the first high sample; returns on the first low sample.
  task automatic pulseWidth(input string req);
    int w = 0;
    while (wdtReset && w < 400) begin
      w++;
      @(negedge clk);
    end
    check(w == PULSE, req, w, PULSE);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: output low during and after reset
    waitN(2);
    check(wdtReset == 1'b0, "R1 during reset", wdtReset, 0);
    doReset();
    check(wdtReset == 1'b0, "R1 after reset", wdtReset, 0);

    // Key-sequence table: R2, R3, R4, R9
    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v = VECS[i];
      doReset();
      mcEn = 1'b1;
      if (v[51]) sfrWrite(v[50:43], v[42:35]);
      if (v[34]) sfrWrite(v[33:26], v[25:18]);
      if (v[17]) sfrWrite(v[16:9], v[8:1]);
      waitN(BASE - 1);
      check(wdtReset == 1'b0, $sformatf("R2 vec%0d before limit", i), wdtReset, 0);
      waitN(1);
      check(wdtReset == v[0], $sformatf("R3 R4 vec%0d at limit", i), wdtReset, v[0]);
      if (v[0]) pulseWidth("R9 width");
      else begin
        waitN(20);
        check(wdtReset == 1'b0, $sformatf("R3 vec%0d stays idle", i), wdtReset, 0);
      end
    end

    // R5 R6 R11: stray writes, then a service on the final-count edge
    doReset();
    mcEn = 1'b1;
    arm();
    waitN(5000);
    sfrWrite(8'hA6, 8'h00);
    sfrWrite(8'hA6, 8'h1E);
    sfrWrite(8'hA6, 8'h55);
    sfrWrite(8'hA5, 8'h33);
    waitN(BASE - 2 - 5004);
    sfrWrite(8'hA6, 8'h1E);
    sfrWrite(8'hA6, 8'hE1);
    check(wdtReset == 1'b0, "R11 service on limit edge", wdtReset, 0);
    waitN(BASE - 1);
    check(wdtReset == 1'b0, "R5 before renewed limit", wdtReset, 0);
    waitN(1);
    check(wdtReset == 1'b1, "R6 R5 renewed limit", wdtReset, 1);
    pulseWidth("R9 width after service");

    // R7: strobe held low for 1000 cycles after arming
    doReset();
    mcEn = 1'b0;
    arm();
    waitN(1000);
    mcEn = 1'b1;
    waitN(BASE - 1);
    check(wdtReset == 1'b0, "R7 gated before limit", wdtReset, 0);
    waitN(1);
    check(wdtReset == 1'b1, "R7 gated at limit", wdtReset, 1);
    pulseWidth("R9 width gated");

    // R8: S = 1 doubles the timeout; R10: re-arm afterwards uses base
    doReset();
    mcEn = 1'b1;
    sfrWrite(8'hA7, 8'hF9);
    arm();
    waitN(2 * BASE - 1);
    check(wdtReset == 1'b0, "R8 S1 before limit", wdtReset, 0);
    waitN(1);
    check(wdtReset == 1'b1, "R8 S1 at limit", wdtReset, 1);
    pulseWidth("R9 width S1");
    waitN(50);
    check(wdtReset == 1'b0, "R10 no second pulse", wdtReset, 0);
    arm();
    waitN(BASE - 1);
    check(wdtReset == 1'b0, "R10 rearm before base limit", wdtReset, 0);
    waitN(1);
    check(wdtReset == 1'b1, "R10 rearm scale cleared", wdtReset, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule